// File: doc/BRIEF.md
# Byte-Lane Data Value Qualifier for Debug Events

This block decides whether a data access that has already hit a debug address comparator should raise a debug event. It looks at the aligned 64-bit data value of the load or store. It compares that value, one byte lane at a time, against a 64-bit reference value. An 8-bit lane-enable mask selects which lanes take part. A 2-bit mode picks how the per-lane results combine:

- no value check at all;
- every enabled lane must match;
- any enabled lane may match;
- some halfword must have all of its enabled lanes matching.

The final event is registered. It is the AND of the access strobe, the address-hit flag and the value condition. It appears one clock after the access is presented and lasts one cycle. One instance is placed per event channel, next to that channel's address comparator.

Top module: `dvq_qualifier`

## Requirements
- R1: With qual_mode_i = 2'b00, a valid access raises the event exactly when addr_hit_i is 1, whatever the data, reference or mask.
- R2: With qual_mode_i = 2'b01, the event is raised only if every lane i with lane_en_i[i] = 1 has acc_data_i[8i+7:8i] equal to cmp_value_i[8i+7:8i].
- R3: With qual_mode_i = 2'b01 and lane_en_i = 8'h00, the value condition holds, so the event follows addr_hit_i.
- R4: With qual_mode_i = 2'b10, the event is raised if at least one enabled lane i has its data byte equal to its reference byte.
- R5: With qual_mode_i = 2'b10 and lane_en_i = 8'h00, no event is raised.
- R6: With qual_mode_i = 2'b11, halfword k covers lanes 2k and 2k+1. The event is raised if some halfword has at least one enabled lane and all of its enabled lanes match.
- R7: With qual_mode_i = 2'b11, a halfword with no enabled lane never counts as matching, so a mask of 8'h00 raises no event.
- R8: dbg_event_o is driven from a register. It equals acc_valid_i & addr_hit_i & condition of the previous cycle, and it is 0 in any cycle that follows a cycle with acc_valid_i = 0.
- R9: While rst_ni is low, dbg_event_o is 0. It is still 0 on the first clock edge after rst_ni rises, because reset release passes through a two-stage synchronizer.
- R10: A valid access with addr_hit_i = 0 never raises the event, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid_i | input | 1 | Data access present this cycle |
| addr_hit_i | input | 1 | Address comparator matched this access |
| acc_data_i | input | 64 | Aligned data value of the access |
| cmp_value_i | input | 64 | Reference value for the lane compare |
| lane_en_i | input | 8 | Lane-enable mask, bit i selects byte lane i |
| qual_mode_i | input | 2 | Combination mode: 00 none, 01 all, 10 any, 11 per-halfword |
| dbg_event_o | output | 1 | Qualified debug event, one cycle after the access |

## Verification
The hardest case to reach is the per-halfword mode. There the outcome depends on how the mask and the lane matches fall within each lane pair: a fully matching halfword must win even when another halfword mismatches, and an unenabled halfword must never win. To reach it, the bench builds the data lane by lane from a chosen match pattern, so it knows exactly which lanes agree with the reference. It then sweeps all 256 masks against a spread of such patterns in every mode. Addr-miss and idle cycles are mixed in, so that the gating and the one-cycle event lifetime are checked alongside.

// File: rtl/dvq_pkg.sv
package dvq_pkg;

  // Combination mode of the per-lane results; encoding is fixed by the port contract
  typedef enum logic [1:0] {
    QM_PASS = 2'b00,
    QM_ALL  = 2'b01,
    QM_ANY  = 2'b10,
    QM_HALF = 2'b11
  } qual_mode_e;

endpackage

// File: rtl/dvq_rst_sync.sv
module dvq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/dvq_lane_cmp.sv
module dvq_lane_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NUM_LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0]    data_i,
  input  logic [DATA_W-1:0]    ref_i,
  output logic [NUM_LANES-1:0] lane_eq_o
);

  // One equality comparator per byte lane, shared by every mode
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_eq_o[g] = (data_i[g*LANE_W +: LANE_W] == ref_i[g*LANE_W +: LANE_W]);
  end

endmodule

// File: rtl/dvq_group_eval.sv
module dvq_group_eval #(
  parameter int NUM_LANES   = 8,
  parameter int GROUP_LANES = 2,
  localparam int NUM_GROUPS = NUM_LANES / GROUP_LANES
) (
  input  logic [NUM_LANES-1:0] lane_eq_i,
  input  logic [NUM_LANES-1:0] lane_en_i,
  output logic                 all_ok_o,
  output logic                 any_ok_o,
  output logic                 grp_ok_o
);

  logic [NUM_LANES-1:0]  hit_en;
  logic [NUM_LANES-1:0]  miss_en;
  logic [NUM_GROUPS-1:0] grp_ok_vec;

  assign hit_en  = lane_eq_i & lane_en_i;
  assign miss_en = ~lane_eq_i & lane_en_i;

  // Vacuous truth on an empty mask is intended for the all-lanes mode
  assign all_ok_o = ~|miss_en;
  assign any_ok_o = |hit_en;

  // A group counts only if it has at least one enabled lane and no enabled miss
  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    assign grp_ok_vec[k] = (|lane_en_i[k*GROUP_LANES +: GROUP_LANES]) &
                           ~(|miss_en[k*GROUP_LANES +: GROUP_LANES]);
  end

  assign grp_ok_o = |grp_ok_vec;

endmodule

// File: rtl/dvq_qualifier.sv
module dvq_qualifier
  import dvq_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int LANE_W      = 8,
  parameter int GROUP_LANES = 2,
  localparam int NUM_LANES  = DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 addr_hit_i,
  input  logic [DATA_W-1:0]    acc_data_i,
  input  logic [DATA_W-1:0]    cmp_value_i,
  input  logic [NUM_LANES-1:0] lane_en_i,
  input  logic [1:0]           qual_mode_i,
  output logic                 dbg_event_o
);

  logic                 rst_sync_n;
  logic [NUM_LANES-1:0] lane_eq;
  logic                 all_ok;
  logic                 any_ok;
  logic                 grp_ok;
  logic                 cond_met;
  qual_mode_e           mode;
  logic                 evt_d;
  logic                 evt_en;
  logic                 evt_q;

  dvq_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  dvq_lane_cmp #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) u_lane_cmp (
    .data_i   (acc_data_i),
    .ref_i    (cmp_value_i),
    .lane_eq_o(lane_eq)
  );

  dvq_group_eval #(
    .NUM_LANES  (NUM_LANES),
    .GROUP_LANES(GROUP_LANES)
  ) u_group_eval (
    .lane_eq_i(lane_eq),
    .lane_en_i(lane_en_i),
    .all_ok_o (all_ok),
    .any_ok_o (any_ok),
    .grp_ok_o (grp_ok)
  );

  assign mode = qual_mode_e'(qual_mode_i);

  always_comb begin
    unique case (mode)
      QM_PASS: cond_met = 1'b1;
      QM_ALL:  cond_met = all_ok;
      QM_ANY:  cond_met = any_ok;
      QM_HALF: cond_met = grp_ok;
      default: cond_met = 1'b0;
    endcase
  end

  // Next state: load on an access, or clear a pending pulse
  always_comb begin
    evt_d  = acc_valid_i & addr_hit_i & cond_met;
    evt_en = acc_valid_i | evt_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      evt_q <= 1'b0;
    end else if (evt_en) begin
      evt_q <= evt_d;
    end
  end

  assign dbg_event_o = evt_q;

endmodule

// File: rtl/dvq_qualifier_chk.sv
module dvq_qualifier_chk #(
  parameter int DATA_W    = 64,
  parameter int NUM_LANES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 addr_hit,
  input logic [DATA_W-1:0]    acc_data,
  input logic [DATA_W-1:0]    cmp_value,
  input logic [NUM_LANES-1:0] lane_en,
  input logic [1:0]           qual_mode,
  input logic                 dbg_event
);

  logic exact;
  assign exact = (acc_data == cmp_value);

  AST_PASS_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_hit && qual_mode == 2'b00) |=> dbg_event); // R1

  AST_ALL_EXACT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_hit && qual_mode == 2'b01 && exact) |=> dbg_event); // R2

  AST_ALL_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_hit && qual_mode == 2'b01 && lane_en == '0) |=> dbg_event); // R3

  AST_ANY_EXACT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_hit && qual_mode == 2'b10 && lane_en != '0 && exact) |=> dbg_event); // R4

  AST_ANY_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_mode == 2'b10 && lane_en == '0) |=> !dbg_event); // R5

  AST_HALF_EXACT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_hit && qual_mode == 2'b11 && lane_en != '0 && exact) |=> dbg_event); // R6

  AST_HALF_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_mode == 2'b11 && lane_en == '0) |=> !dbg_event); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid) |=> !dbg_event); // R8

  AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_hit) |=> !dbg_event); // R10

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!dbg_event); // R9
    end
  end

endmodule

bind dvq_qualifier dvq_qualifier_chk #(
  .DATA_W   (DATA_W),
  .NUM_LANES(NUM_LANES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .acc_valid(acc_valid_i),
  .addr_hit (addr_hit_i),
  .acc_data (acc_data_i),
  .cmp_value(cmp_value_i),
  .lane_en  (lane_en_i),
  .qual_mode(qual_mode_i),
  .dbg_event(dbg_event_o)
);

// File: tb/tb_dvq_qualifier.sv
module tb_dvq_qualifier;

  logic        clk;
  logic        rst_ni;
  logic        acc_valid_i;
  logic        addr_hit_i;
  logic [63:0] acc_data_i;
  logic [63:0] cmp_value_i;
  logic [7:0]  lane_en_i;
  logic [1:0]  qual_mode_i;
  logic        dbg_event_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dvq_qualifier dut (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .acc_valid_i(acc_valid_i),
    .addr_hit_i (addr_hit_i),
    .acc_data_i (acc_data_i),
    .cmp_value_i(cmp_value_i),
    .lane_en_i  (lane_en_i),
    .qual_mode_i(qual_mode_i),
    .dbg_event_o(dbg_event_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic exp);
    checks++;
    if (dbg_event_o !== exp) begin
      errors++;
      $display("FAIL %s: mode=%b en=%h valid=%b hit=%b event=%b expected=%b",
               tag, qual_mode_i, lane_en_i, acc_valid_i, addr_hit_i, dbg_event_o, exp);
    end
  endtask

  // Value condition computed from the lane match pattern the bench built
  function automatic logic exp_cond(input logic [1:0] md, input logic [7:0] en,
                                    input logic [7:0] mp);
    logic r;
    case (md)
      2'b00: r = 1'b1;
      2'b01: r = ((en & ~mp) == 8'h00);
      2'b10: r = ((en & mp) != 8'h00);
      default: begin
        r = 1'b0;
        for (int k = 0; k < 4; k++) begin
          if (en[2*k +: 2] != 2'b00 && (en[2*k +: 2] & ~mp[2*k +: 2]) == 2'b00) r = 1'b1;
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic v, input logic h, input logic [1:0] md,
                                   input logic [7:0] en);
    if (!v) return "R8";
    if (!h) return "R10";
    case (md)
      2'b00: return "R1";
      2'b01: return (en == 8'h00) ? "R3" : "R2";
      2'b10: return (en == 8'h00) ? "R5" : "R4";
      default: begin
        for (int k = 0; k < 4; k++) if (en[2*k +: 2] == 2'b00) return "R7";
        return "R6";
      end
    endcase
  endfunction

  task automatic drive(input logic v, input logic h, input logic [1:0] md,
                       input logic [7:0] en, input logic [7:0] mp, input logic [63:0] refv);
    acc_valid_i = v;
    addr_hit_i  = h;
    qual_mode_i = md;
    lane_en_i   = en;
    cmp_value_i = refv;
    for (int i = 0; i < 8; i++) begin
      acc_data_i[8*i +: 8] = mp[i] ? refv[8*i +: 8] : (refv[8*i +: 8] ^ (8'h01 << i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    drive(1'b1, 1'b1, 2'b00, 8'hFF, 8'hFF, 64'h0);
    repeat (3) @(negedge clk);
    check("R9", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9", 1'b0);
    drive(1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 64'h0);
    repeat (3) @(negedge clk);
    check("R8", 1'b0);

    // Single pulse then idle: event lasts one cycle
    drive(1'b1, 1'b1, 2'b00, 8'h00, 8'h00, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    check("R1", 1'b1);
    drive(1'b0, 1'b1, 2'b00, 8'h00, 8'h00, 64'h0);
    @(negedge clk);
    check("R8", 1'b0);

    // Sweep: every mode, every mask, a spread of lane match patterns
    for (int md = 0; md < 4; md++) begin
      for (int en = 0; en < 256; en++) begin
        for (int m = 0; m < 32; m++) begin
          logic [7:0]  mp;
          logic [63:0] refv;
          logic        v;
          logic        h;
          logic        exp;
          mp   = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : 8'((m * 53) ^ en);
          refv = 64'h0123_4567_89AB_CDEF ^ {8{8'(m * 7 + en)}};
          v    = (m != 7);
          h    = (m != 5);
          exp  = v & h & exp_cond(2'(md), 8'(en), mp);
          drive(v, h, 2'(md), 8'(en), mp, refv);
          @(negedge clk);
          check(tag_of(v, h, 2'(md), 8'(en)), exp);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule